// File: doc/BRIEF.md
# Programmable Row Switching Sequencer

This block drives the gate and clear strobes of every row in a pixel matrix. It steps through a short program held in an on-chip table. Each table word names one row and gives how long that row's gate strobe lasts and how long its clear strobe lasts. A word also carries a flag that ends the program. The row order is arbitrary, so a row may appear several times in the program to be read more often. A per-row enable mask lets defective rows drop out of the program without rewriting it. The outputs are logic-level. The high-voltage drivers sit outside the block.

Several of these blocks share one clock and are chained by a token. A block that is idle and sees its token input starts its program on the next cycle. On the last cycle of its last clear strobe it raises its token output for one cycle and returns to idle, so the next block in the chain starts on the following cycle with no dead time. A host loads the table and the mask through a two-wire serial port. Loading is allowed only while the block is idle. A load attempted during a run is dropped and recorded in a sticky error flag.

Top module: `row_seq_top`

## Requirements
- R1: The serial port takes frames of 24 bits, most significant bit first, one bit per clock while `cfg_en` is high. Bit 23 selects the target: 0 for a table word, 1 for a mask bit. Bits 22:16 are the address. Bits 15:0 are the data. A frame takes effect on the second clock edge after its last bit. Whenever `cfg_en` is low, the bit counter restarts.
- R2: After reset, all gate and clear outputs, `token_out`, `busy` and `cfg_err` are low.
- R3: A table word holds the row in bits 15:9, the gate length field G in bits 8:5, the clear length field C in bits 4:1 and the end flag in bit 0. A table write uses the low four address bits as the entry index. When `token_in` is high at a clock edge while the block is idle, the gate of the first enabled entry's row is high from the next cycle on, for G+1 cycles.
- R4: After a row's gate ends, one cycle follows with no output high. The same row's clear is then high for C+1 cycles. At most one gate or one clear output is high in any cycle.
- R5: Entries run in table order. The gate of the next entry starts on the cycle right after the previous clear ends. A row listed more than once is strobed each time it is listed.
- R6: The program ends at the first entry whose end flag is set, or at entry 15 if no entry has the flag set.
- R7: An entry whose row is disabled in the mask is skipped and takes no cycles.
- R8: `token_out` is high for exactly one cycle, on the last cycle of the final clear, and `busy` falls on the next cycle. If no entry is enabled, `token_out` is high on the cycle after `token_in`.
- R9: A frame that takes effect while `busy` is high changes nothing and sets `cfg_err`. Only reset clears `cfg_err`.
- R10: `token_in` has no effect while `busy` is high.
- R11: After reset, every row is enabled. A mask write sets the enable of the row at the address from data bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Serial frame enable |
| cfg_dat | input | 1 | Serial frame data, MSB first |
| token_in | input | 1 | Token from the previous block in the chain |
| gate_o | output | 128 | Gate strobes, one per row |
| clear_o | output | 128 | Clear strobes, one per row |
| token_out | output | 1 | Token to the next block in the chain |
| busy | output | 1 | High while a program runs |
| cfg_err | output | 1 | Sticky flag: a load was attempted during a run |

## Verification
The hardest case to reach is a serial load that takes effect in the middle of a run. It matters because the dropped write must leave both the table and the mask exactly as they were. The bench builds a program lasting close to seventy cycles and starts it. It then shifts in a full table frame and pulses `token_in` while the run is still going. It checks every cycle of that run, and then replays the program to show that neither the stray frame nor the stray token changed anything. Masked entries at the start, middle and end of the program, and a program with every row disabled, come from directed tests. Randomly generated programs and masks cover the rest.

// File: rtl/row_seq_pkg.sv
package row_seq_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_GATE = 2'd1,
    S_GAP  = 2'd2,
    S_CLR  = 2'd3
  } seq_state_e;

  // frame = target bit + address field + data word
  function automatic int frame_bits(input int addr_w, input int word_w);
    return 1 + addr_w + word_w;
  endfunction

  function automatic int word_bits(input int row_w, input int dur_w);
    return row_w + 2 * dur_w + 1;
  endfunction

endpackage

// File: rtl/row_seq_cfg.sv
module row_seq_cfg #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic               cfg_dat,
  output logic               frm_stb,
  output logic [FRAME_W-1:0] frm
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] shreg;
  logic               frame_end;

  assign frame_end = cfg_en && (bit_cnt == CNT_W'(FRAME_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
      frm_stb <= 1'b0;
      frm     <= '0;
    end else begin
      frm_stb <= 1'b0;
      if (!cfg_en) begin
        bit_cnt <= '0;
      end else begin
        shreg <= {shreg[FRAME_W-2:0], cfg_dat};
        if (frame_end) begin
          bit_cnt <= '0;
          frm_stb <= 1'b1;
          frm     <= {shreg[FRAME_W-2:0], cfg_dat};
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  assert_frame_after_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frm_stb |-> $past(cfg_en));

endmodule

// File: rtl/row_seq_store.sv
module row_seq_store #(
  parameter int NROWS   = 128,
  parameter int DEPTH   = 16,
  parameter int ADDR_FW = 7,
  parameter int WORD_W  = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            frm_stb,
  input  logic [1+ADDR_FW+WORD_W-1:0]     frm,
  input  logic                            busy,
  output logic [WORD_W-1:0]               tbl [DEPTH],
  output logic [NROWS-1:0]                row_en,
  output logic                            cfg_err
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int ROW_W = $clog2(NROWS);

  logic               is_mask;
  logic [ADDR_FW-1:0] addr;
  logic [WORD_W-1:0]  data;
  logic               wr_ok;
  logic               wr_drop;

  assign is_mask = frm[ADDR_FW+WORD_W];
  assign addr    = frm[ADDR_FW+WORD_W-1:WORD_W];
  assign data    = frm[WORD_W-1:0];
  assign wr_ok   = frm_stb && !busy;
  assign wr_drop = frm_stb && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
      row_en  <= '1;
      cfg_err <= 1'b0;
    end else begin
      if (wr_drop) cfg_err <= 1'b1;
      if (wr_ok) begin
        if (is_mask) row_en[addr[ROW_W-1:0]] <= data[0];
        else         tbl[addr[IDX_W-1:0]]    <= data;
      end
    end
  end

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  assert_busy_write_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> cfg_err);
  assert_busy_write_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> $stable(row_en));

endmodule

// File: rtl/row_seq_core.sv
module row_seq_core
  import row_seq_pkg::*;
#(
  parameter int NROWS = 128,
  parameter int DEPTH = 16,
  parameter int DUR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [$clog2(NROWS)+2*DUR_W:0] tbl [DEPTH],
  input  logic [NROWS-1:0]    row_en,
  input  logic                token_in,
  output logic [NROWS-1:0]    gate_o,
  output logic [NROWS-1:0]    clear_o,
  output logic                token_out,
  output logic                busy
);
  localparam int ROW_W  = $clog2(NROWS);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int WORD_W = word_bits(ROW_W, DUR_W);

  function automatic logic [ROW_W-1:0] f_row(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: ROW_W];
  endfunction
  function automatic logic [DUR_W-1:0] f_gate_len(input logic [WORD_W-1:0] w);
    return w[2*DUR_W -: DUR_W];
  endfunction
  function automatic logic [DUR_W-1:0] f_clr_len(input logic [WORD_W-1:0] w);
    return w[DUR_W -: DUR_W];
  endfunction
  function automatic logic f_end(input logic [WORD_W-1:0] w);
    return w[0];
  endfunction

  // first enabled entry at or after s, not crossing an end flag
  function automatic logic [IDX_W:0] seek(input int s,
                                          input logic [WORD_W-1:0] t [DEPTH],
                                          input logic [NROWS-1:0] en);
    logic             hit;
    logic             halt;
    logic [IDX_W-1:0] at;
    hit  = 1'b0;
    halt = 1'b0;
    at   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!halt && !hit && i >= s && en[f_row(t[i])]) begin
        hit = 1'b1;
        at  = IDX_W'(i);
      end
      if (i >= s && f_end(t[i])) halt = 1'b1;
    end
    return {hit, at};
  endfunction

  seq_state_e       st;
  logic [DUR_W-1:0] cnt;
  logic [IDX_W-1:0] ptr;
  logic             pass;
  logic [IDX_W:0]   first_hit;
  logic [IDX_W:0]   next_hit;
  logic             is_final;
  logic [ROW_W-1:0] cur_row;

  // named internal events
  logic ev_start;
  logic ev_pass;
  logic ev_gate_done;
  logic ev_clr_done;
  logic ev_release;

  always_comb begin
    first_hit = seek(0, tbl, row_en);
    next_hit  = seek(int'(ptr) + 1, tbl, row_en);
  end

  assign is_final     = f_end(tbl[ptr]) || !next_hit[IDX_W];
  assign cur_row      = f_row(tbl[ptr]);
  assign ev_start     = (st == S_IDLE) && !pass && token_in && first_hit[IDX_W];
  assign ev_pass      = (st == S_IDLE) && !pass && token_in && !first_hit[IDX_W];
  assign ev_gate_done = (st == S_GATE) && (cnt == '0);
  assign ev_clr_done  = (st == S_CLR) && (cnt == '0);
  assign ev_release   = ev_clr_done && is_final;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      ptr  <= '0;
      pass <= 1'b0;
    end else begin
      pass <= ev_pass;
      unique case (st)
        S_IDLE: begin
          if (ev_start) begin
            st  <= S_GATE;
            ptr <= first_hit[IDX_W-1:0];
            cnt <= f_gate_len(tbl[first_hit[IDX_W-1:0]]);
          end
        end
        S_GATE: begin
          if (ev_gate_done) st <= S_GAP;
          else              cnt <= cnt - 1'b1;
        end
        S_GAP: begin
          st  <= S_CLR;
          cnt <= f_clr_len(tbl[ptr]);
        end
        S_CLR: begin
          if (ev_release) begin
            st <= S_IDLE;
          end else if (ev_clr_done) begin
            st  <= S_GATE;
            ptr <= next_hit[IDX_W-1:0];
            cnt <= f_gate_len(tbl[next_hit[IDX_W-1:0]]);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar r = 0; r < NROWS; r++) begin : g_row_drv
    assign gate_o[r]  = (st == S_GATE) && (cur_row == ROW_W'(r));
    assign clear_o[r] = (st == S_CLR)  && (cur_row == ROW_W'(r));
  end

  assign token_out = pass || ev_release;
  assign busy      = (st != S_IDLE) || pass;

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gate_o, clear_o}));
  assert_gap_after_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|gate_o) ##1 !(|gate_o) |-> clear_o == '0);
  assert_token_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    token_out && !token_in |=> !token_out);
  assert_token_on_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    token_out && !pass |-> |clear_o);
  assert_token_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    token_out && !token_in |=> !busy);
  assert_busy_token_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GATE) && !ev_gate_done |=> st == S_GATE);

endmodule

// File: rtl/row_seq_top.sv
module row_seq_top
  import row_seq_pkg::*;
#(
  parameter int NROWS = 128,
  parameter int DEPTH = 16,
  parameter int DUR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_dat,
  input  logic             token_in,
  output logic [NROWS-1:0] gate_o,
  output logic [NROWS-1:0] clear_o,
  output logic             token_out,
  output logic             busy,
  output logic             cfg_err
);
  localparam int ROW_W   = $clog2(NROWS);
  localparam int WORD_W  = word_bits(ROW_W, DUR_W);
  localparam int FRAME_W = frame_bits(ROW_W, WORD_W);

  logic               frm_stb;
  logic [FRAME_W-1:0] frm;
  logic [WORD_W-1:0]  tbl [DEPTH];
  logic [NROWS-1:0]   row_en;

  row_seq_cfg #(.FRAME_W(FRAME_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .cfg_dat (cfg_dat),
    .frm_stb (frm_stb),
    .frm     (frm)
  );

  row_seq_store #(
    .NROWS   (NROWS),
    .DEPTH   (DEPTH),
    .ADDR_FW (ROW_W),
    .WORD_W  (WORD_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .frm_stb (frm_stb),
    .frm     (frm),
    .busy    (busy),
    .tbl     (tbl),
    .row_en  (row_en),
    .cfg_err (cfg_err)
  );

  row_seq_core #(
    .NROWS (NROWS),
    .DEPTH (DEPTH),
    .DUR_W (DUR_W)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tbl       (tbl),
    .row_en    (row_en),
    .token_in  (token_in),
    .gate_o    (gate_o),
    .clear_o   (clear_o),
    .token_out (token_out),
    .busy      (busy)
  );

endmodule

// File: tb/row_seq_top_tb.sv
module row_seq_top_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_en = 1'b0;
  logic         cfg_dat = 1'b0;
  logic         token_in = 1'b0;
  logic [127:0] gate_o, clear_o;
  logic         token_out, busy, cfg_err;

  int total = 0;
  int bad = 0;

  // bench model of table and mask
  logic [15:0] m_tbl [16];
  bit          m_en [128];
  int          eg [700];
  int          ec [700];
  bit          et [700];
  int          n_exp;

  always #10 clk = ~clk;

  row_seq_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_dat(cfg_dat),
    .token_in(token_in), .gate_o(gate_o), .clear_o(clear_o),
    .token_out(token_out), .busy(busy), .cfg_err(cfg_err)
  );

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [15:0] mk(input int row, input int gl, input int cl, input bit last);
    return {7'(row), 4'(gl), 4'(cl), last};
  endfunction

  function automatic logic [127:0] onehot(input int r);
    logic [127:0] v;
    v = '0;
    if (r >= 0) v[r] = 1'b1;
    return v;
  endfunction

  // expected trace from the requirements: R3 R4 R5 R6 R7 R8
  function automatic void build();
    bit stop;
    int row;
    n_exp = 0;
    stop = 0;
    for (int i = 0; i < 16; i++) begin
      if (!stop) begin
        row = int'(m_tbl[i][15:9]);
        if (m_en[row]) begin
          for (int k = 0; k <= int'(m_tbl[i][8:5]); k++) begin
            eg[n_exp] = row; ec[n_exp] = -1; et[n_exp] = 0; n_exp++;
          end
          eg[n_exp] = -1; ec[n_exp] = -1; et[n_exp] = 0; n_exp++;
          for (int k = 0; k <= int'(m_tbl[i][4:1]); k++) begin
            eg[n_exp] = -1; ec[n_exp] = row; et[n_exp] = 0; n_exp++;
          end
        end
        if (m_tbl[i][0]) stop = 1;
      end
    end
    if (n_exp == 0) begin
      eg[0] = -1; ec[0] = -1; n_exp = 1;
    end
    et[n_exp-1] = 1;
  endfunction

  task automatic send(input bit kind, input int addr, input logic [15:0] data, input bit apply);
    logic [23:0] f;
    f = {kind, 7'(addr), data};
    for (int i = 23; i >= 0; i--) begin
      cfg_en = 1'b1; cfg_dat = f[i];
      @(negedge clk);
    end
    cfg_en = 1'b0; cfg_dat = 1'b0;
    repeat (3) @(negedge clk);
    if (apply) begin
      if (kind) m_en[addr] = data[0];
      else      m_tbl[addr % 16] = data;
    end
  endtask

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic watch(input string tag);
    for (int c = 0; c < n_exp; c++) begin
      chk({tag, " gate"},  gate_o,  onehot(eg[c]));
      chk({tag, " clear"}, clear_o, onehot(ec[c]));
      chk({tag, " token_out R8"}, 128'(token_out), 128'(et[c]));
      chk({tag, " busy R8"}, 128'(busy), 128'(1));
      @(negedge clk);
    end
    chk({tag, " idle after token R8"}, {126'(0), token_out, busy}, 128'(0));
    chk({tag, " quiet after run R8"}, gate_o | clear_o, 128'(0));
  endtask

  task automatic disturb();
    repeat (3) @(negedge clk);
    token_in = 1'b1;                          // R10: ignored while busy
    @(negedge clk);
    token_in = 1'b0;
    send(1'b0, 0, mk(99, 15, 15, 1'b1), 1'b0); // R9: dropped
  endtask

  task automatic run(input string tag, input bit inject);
    build();
    token_in = 1'b1;
    @(negedge clk);
    token_in = 1'b0;
    if (inject) begin
      fork
        watch(tag);
        disturb();
      join
    end else begin
      watch(tag);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) m_tbl[i] = '0;
    for (int i = 0; i < 128; i++) m_en[i] = 1;
    repeat (3) @(negedge clk);
    chk("R2 reset gate/clear", gate_o | clear_o, 128'(0));
    chk("R2 reset flags", {125'(0), token_out, busy, cfg_err}, 128'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R4 R5 R6: directed program, a repeated row, an end flag at entry 3
    send(0, 0, mk(5, 0, 0, 0), 1);
    send(0, 1, mk(127, 2, 1, 0), 1);
    send(0, 2, mk(5, 1, 3, 0), 1);
    send(0, 3, mk(0, 3, 0, 1), 1);
    send(0, 4, mk(9, 0, 0, 0), 1);
    run("R3 R5 R6 directed", 0);

    // R7 R11: mask out first and middle rows
    send(1, 5, 16'h0000, 1);
    run("R7 skip masked rows", 0);
    send(1, 0, 16'h0000, 1);
    run("R7 skip final masked entry", 0);

    // R8: nothing enabled -> token passes the next cycle
    send(1, 127, 16'h0000, 1);
    run("R8 all masked pass", 0);

    // R11: re-enable rows
    send(1, 5, 16'h0001, 1);
    send(1, 0, 16'h0001, 1);
    send(1, 127, 16'h0001, 1);
    run("R11 mask re-enable", 0);

    // R6: no end flag anywhere -> all 16 entries
    for (int i = 0; i < 16; i++) send(0, i, mk(i * 8, i % 3, (i + 1) % 2, 0), 1);
    run("R6 full table", 0);

    // R9 R10: load and token during a run are ignored
    chk("R9 err clear before", 128'(cfg_err), 128'(0));
    for (int i = 0; i < 4; i++) send(0, i, mk(20 + i, 7, 7, i == 3), 1);
    run("R10 token while busy", 1);
    chk("R9 err set", 128'(cfg_err), 128'(1));
    run("R9 table unchanged", 0);
    chk("R9 err sticky", 128'(cfg_err), 128'(1));

    // random programs and masks
    for (int it = 0; it < 20; it++) begin
      for (int i = 0; i < 16; i++) begin
        int row;
        row = int'($urandom_range(0, 127));
        send(0, i, mk(row, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 7) == 0), 1);
        send(1, row, {15'd0, 1'($urandom_range(0, 3) != 0)}, 1);
      end
      run("R5 R7 random", 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule